// File: doc/BRIEF.md
# PRBS Generator with Mark-Ratio Shaping

A serial test-pattern source that emits one bit for each clock on which it is enabled. Inside, a Fibonacci linear-feedback shift register runs a maximal-length sequence of one of seven orders. A shaping stage then lowers the density of ones by taking the AND of two or three taps of the same sequence. An XOR stage at the end can complement the stream, which gives the high-density variants.

The `run` input is both the start control and the restart control. While `run` is low, the register holds its all-ones seed, the output sits at 0, and the configuration inputs are captured. When `run` goes high, the sequence starts from the seed and follows the captured configuration. Configuration changes made while running are ignored until the next restart. The synchronous reset `rst_n` behaves the same way as a low `run`.

Top module: `prbs_mark_gen`

## Requirements
- R1: `order_sel` codes 0..6 select orders n = 7, 9, 11, 15, 20, 23, 31, with feedback taps t = 6, 5, 9, 14, 17, 18, 28 for those orders. Code 7 acts as code 0. The raw sequence obeys p[k] = 1 for k < n and p[k] = p[k-n] XOR p[k-t] after that, so its period is 2^n-1.
- R2: During reset and on the cycle after any clock edge at which `run` is low, `bit_out` is 0. After a restart, the first output is derived from sequence index 0.
- R3: `ratio_sel` = 0 selects ratio 1/2, and output k is p[k]. Over one full period the output holds 2^(n-1) ones.
- R4: `ratio_sel` = 1 selects ratio 1/4, and output k is p[k] AND p[k+d]. Over one period the output holds 2^(n-2) ones.
- R5: `ratio_sel` = 2 selects ratio 1/8, and output k is p[k] AND p[k+d] AND p[k+2d]. Over one period the output holds 2^(n-3) ones.
- R6: `ratio_sel` = 3 forces the value before inversion to a constant 0.
- R7: `invert` = 1 complements every output bit, so the count of ones over a period becomes (2^n-1) minus the uninverted count.
- R8: `shift_sel` = 0 sets the tap spacing d = 1, and `shift_sel` = 1 sets d = 3.
- R9: While `run` is high and `en` is low, neither `bit_out` nor the sequence position changes. When `en` returns high, the sequence resumes at the next index.
- R10: Changes to `order_sel`, `ratio_sel`, `shift_sel` or `invert` while `run` is high have no effect until `run` has been low for at least one clock edge.
- R11: The active bits of the shift register are never all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| en | input | 1 | Clock enable; advances the sequence by one bit |
| run | input | 1 | High to run, low to hold at the seed and capture the configuration |
| order_sel | input | 3 | Sequence order code |
| ratio_sel | input | 2 | Mark-ratio code |
| shift_sel | input | 1 | Tap spacing select (1 or 3 bits) |
| invert | input | 1 | Complement the output |
| bit_out | output | 1 | Serial pattern bit |

## Verification
For every order code, a 200-bit prefix is compared against a reference recurrence computed in the bench. A wrong feedback tap or a wrong order mapping shows up as a mismatch within the first few dozen bits. On order 9, every combination of ratio, spacing and inversion is compared against the reference. This separates a tap taken at the wrong spacing from a wrong combining function, which a density count alone cannot do. For orders 7, 9 and 11, exact ones counts over a full period cover every configuration, and order 15 is counted at ratio 1/2. These counts confirm the maximal period and the exact densities 1/2, 1/4, 1/8, 0 and their complements. Enable pauses, mid-run configuration changes and restarts are each checked against the reference index at which the output must resume.

// File: rtl/prbs_mark_pkg.sv
package prbs_mark_pkg;

   localparam int unsigned NUM_ORDERS = 7;
   localparam int unsigned TABLE_MAX  = 31;

   typedef enum logic [1:0] {
      RATIO_HALF    = 2'd0,
      RATIO_QUARTER = 2'd1,
      RATIO_EIGHTH  = 2'd2,
      RATIO_ZERO    = 2'd3
   } ratio_e;

   typedef logic [2:0] order_code_t;

   typedef struct packed {
      order_code_t order;
      ratio_e      ratio;
      logic        wide_shift;
      logic        invert;
   } cfg_t;

   // Register length for an order index.
   function automatic int unsigned order_len(input int unsigned idx);
      case (idx)
         0:       return 7;
         1:       return 9;
         2:       return 11;
         3:       return 15;
         4:       return 20;
         5:       return 23;
         6:       return 31;
         default: return 7;
      endcase
   endfunction

   // Second feedback tap (x^t term of x^n + x^t + 1).
   function automatic int unsigned order_tap(input int unsigned idx);
      case (idx)
         0:       return 6;
         1:       return 5;
         2:       return 9;
         3:       return 14;
         4:       return 17;
         5:       return 18;
         6:       return 28;
         default: return 6;
      endcase
   endfunction

   // Map the select code onto a table index; the spare code folds to 0.
   function automatic logic [2:0] order_index(input order_code_t code);
      return (32'(code) >= NUM_ORDERS) ? 3'd0 : code;
   endfunction

endpackage

// File: rtl/prbs_lfsr_core.sv
module prbs_lfsr_core #(
   parameter int unsigned WIDTH = 31
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             restart,
   input  logic             advance,
   input  logic             feedback,
   output logic [WIDTH-1:0] state
);

   if (WIDTH < 2) begin : g_width_bad
      $error("prbs_lfsr_core: WIDTH must be at least 2");
   end

   // Oldest bit sits at the top; new bits enter at bit 0.
   always_ff @(posedge clk) begin
      if (!rst_n || restart) begin
         state <= '1;
      end else if (advance) begin
         state <= {state[WIDTH-2:0], feedback};
      end
   end

endmodule

// File: rtl/prbs_tap_select.sv
module prbs_tap_select
   import prbs_mark_pkg::*;
#(
   parameter int unsigned WIDTH      = 31,
   parameter int unsigned SHIFT_NEAR = 1,
   parameter int unsigned SHIFT_FAR  = 3
) (
   input  logic [WIDTH-1:0] state,
   input  logic [2:0]       order_idx,
   input  logic             wide_shift,
   output logic             feedback,
   output logic [2:0]       taps
);

   localparam int unsigned SPAN_MAX = 2 * ((SHIFT_FAR > SHIFT_NEAR) ? SHIFT_FAR : SHIFT_NEAR);

   if (SPAN_MAX >= order_len(0)) begin : g_span_bad
      $error("prbs_tap_select: tap span exceeds the shortest register");
   end

   logic       fb_vec   [NUM_ORDERS];
   logic [2:0] near_vec [NUM_ORDERS];
   logic [2:0] far_vec  [NUM_ORDERS];

   // One tap network per supported order; the mux below picks one.
   for (genvar g = 0; g < NUM_ORDERS; g++) begin : g_order
      localparam int unsigned N = order_len(g);
      localparam int unsigned T = order_tap(g);
      assign fb_vec[g]   = state[N-1] ^ state[T-1];
      assign near_vec[g] = {state[N-1-2*SHIFT_NEAR], state[N-1-SHIFT_NEAR], state[N-1]};
      assign far_vec[g]  = {state[N-1-2*SHIFT_FAR],  state[N-1-SHIFT_FAR],  state[N-1]};
   end

   always_comb begin
      feedback = 1'b0;
      taps     = '0;
      for (int i = 0; i < NUM_ORDERS; i++) begin
         if (32'(order_idx) == i) begin
            feedback = fb_vec[i];
            taps     = wide_shift ? far_vec[i] : near_vec[i];
         end
      end
   end

endmodule

// File: rtl/prbs_mark_shaper.sv
module prbs_mark_shaper
   import prbs_mark_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       active,
   input  logic       advance,
   input  logic [2:0] taps,
   input  ratio_e     ratio,
   input  logic       invert,
   output logic       bit_out
);

   logic shaped;

   // Taps are p[k], p[k+d], p[k+2d]; ANDing them thins the ones.
   always_comb begin
      case (ratio)
         RATIO_HALF:    shaped = taps[0];
         RATIO_QUARTER: shaped = taps[0] & taps[1];
         RATIO_EIGHTH:  shaped = &taps;
         default:       shaped = 1'b0;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n || !active) begin
         bit_out <= 1'b0;
      end else if (advance) begin
         bit_out <= shaped ^ invert;
      end
   end

endmodule

// File: rtl/prbs_mark_gen.sv
module prbs_mark_gen
   import prbs_mark_pkg::*;
#(
   parameter int unsigned MAX_ORDER  = 31,
   parameter int unsigned SHIFT_NEAR = 1,
   parameter int unsigned SHIFT_FAR  = 3
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       en,
   input  logic       run,
   input  logic [2:0] order_sel,
   input  logic [1:0] ratio_sel,
   input  logic       shift_sel,
   input  logic       invert,
   output logic       bit_out
);

   if (MAX_ORDER < TABLE_MAX) begin : g_order_bad
      $error("prbs_mark_gen: MAX_ORDER below the longest supported order");
   end
   if (SHIFT_NEAR == 0 || SHIFT_FAR == 0) begin : g_shift_bad
      $error("prbs_mark_gen: tap spacings must be nonzero");
   end

   cfg_t                 cfg_q;
   logic [MAX_ORDER-1:0] lfsr_state;
   logic [2:0]           order_idx;
   logic                 feedback;
   logic [2:0]           taps;
   logic                 advance;

   // Configuration is captured only while stopped or in reset.
   always_ff @(posedge clk) begin
      if (!rst_n || !run) begin
         cfg_q <= '{order: order_sel, ratio: ratio_e'(ratio_sel),
                    wide_shift: shift_sel, invert: invert};
      end
   end

   assign order_idx = order_index(cfg_q.order);
   assign advance   = run & en;

   prbs_lfsr_core #(.WIDTH(MAX_ORDER)) i_core (
      .clk      (clk),
      .rst_n    (rst_n),
      .restart  (!run),
      .advance  (advance),
      .feedback (feedback),
      .state    (lfsr_state)
   );

   prbs_tap_select #(
      .WIDTH      (MAX_ORDER),
      .SHIFT_NEAR (SHIFT_NEAR),
      .SHIFT_FAR  (SHIFT_FAR)
   ) i_taps (
      .state      (lfsr_state),
      .order_idx  (order_idx),
      .wide_shift (cfg_q.wide_shift),
      .feedback   (feedback),
      .taps       (taps)
   );

   prbs_mark_shaper i_shaper (
      .clk     (clk),
      .rst_n   (rst_n),
      .active  (run),
      .advance (advance),
      .taps    (taps),
      .ratio   (cfg_q.ratio),
      .invert  (cfg_q.invert),
      .bit_out (bit_out)
   );

endmodule

// File: rtl/prbs_mark_chk.sv
module prbs_mark_chk
   import prbs_mark_pkg::*;
#(
   parameter int unsigned WIDTH = 31
) (
   input logic             clk,
   input logic             rst_n,
   input logic             en,
   input logic             run,
   input logic             bit_out,
   input cfg_t             cfg,
   input logic [WIDTH-1:0] state
);

   logic [WIDTH-1:0] mask;

   always_comb begin
      for (int i = 0; i < WIDTH; i++) begin
         mask[i] = (i < order_len(32'(order_index(cfg.order))));
      end
   end

   // R2
   idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !run |=> (bit_out == 1'b0));

   // R9
   hold_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (run && !en) |=> $stable(bit_out));

   // R9
   hold_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (run && !en) |=> $stable(state));

   // R10
   cfg_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (run && $past(run) && $past(rst_n)) |-> $stable(cfg));

   // R6
   zero_ratio_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (run && en && cfg.ratio == RATIO_ZERO) |=> (bit_out == $past(cfg.invert)));

   // R11
   nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state & mask) != '0);

endmodule

bind prbs_mark_gen prbs_mark_chk #(.WIDTH(MAX_ORDER)) i_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .en      (en),
   .run     (run),
   .bit_out (bit_out),
   .cfg     (cfg_q),
   .state   (lfsr_state)
);

// File: tb/test_prbs_mark_gen.sv
module test_prbs_mark_gen;

   localparam int CLK_PERIOD = 10;
   localparam int WATCHDOG   = 190000;
   localparam int REF_LEN    = 200;

   logic       clk = 1'b0;
   logic       rst_n, en, run, shift_sel, invert;
   logic [2:0] order_sel;
   logic [1:0] ratio_sel;
   logic       bit_out;

   int checks   = 0;
   int failures = 0;
   bit finished = 0;

   logic pref [0:REF_LEN+7];

   always #(CLK_PERIOD/2) clk = ~clk;

   prbs_mark_gen i_prbs_mark_gen (
      .clk (clk), .rst_n (rst_n), .en (en), .run (run),
      .order_sel (order_sel), .ratio_sel (ratio_sel),
      .shift_sel (shift_sel), .invert (invert), .bit_out (bit_out)
   );

   // R1 order and tap tables.
   function automatic int len_of(input int code);
      case (code)
         1: return 9;   2: return 11;  3: return 15;
         4: return 20;  5: return 23;  6: return 31;
         default: return 7;
      endcase
   endfunction

   function automatic int tap_of(input int code);
      case (code)
         1: return 5;   2: return 9;   3: return 14;
         4: return 17;  5: return 18;  6: return 28;
         default: return 6;
      endcase
   endfunction

   task automatic gen_ref(input int code);
      int n = len_of(code);
      int t = tap_of(code);
      for (int k = 0; k <= REF_LEN + 7; k++) begin
         if (k < n) pref[k] = 1'b1;
         else       pref[k] = pref[k-n] ^ pref[k-t];
      end
   endtask

   function automatic logic ref_bit(input int k, input int ratio, input int wide, input logic inv);
      int   d = (wide != 0) ? 3 : 1;
      logic v;
      case (ratio)
         0:       v = pref[k];
         1:       v = pref[k] & pref[k+d];
         2:       v = pref[k] & pref[k+d] & pref[k+2*d];
         default: v = 1'b0;
      endcase
      return v ^ inv;
   endfunction

   task automatic check(input bit ok, input string req, input string what,
                        input longint act, input longint exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   task automatic next_bit(output logic b);
      @(posedge clk);
      @(negedge clk);
      b = bit_out;
   endtask

   task automatic restart_cfg(input int code, input int ratio, input int wide, input logic inv);
      @(negedge clk);
      run       = 1'b0;
      order_sel = code[2:0];
      ratio_sel = ratio[1:0];
      shift_sel = wide[0];
      invert    = inv;
      @(negedge clk);
      @(negedge clk);
      run = 1'b1;
      en  = 1'b1;
   endtask

   task automatic ref_run(input int code, input int ratio, input int wide,
                          input logic inv, input string req);
      int   bad = 0;
      int   first = -1;
      logic b;
      gen_ref(code);
      restart_cfg(code, ratio, wide, inv);
      for (int k = 0; k < REF_LEN; k++) begin
         next_bit(b);
         if (b !== ref_bit(k, ratio, wide, inv)) begin
            bad++;
            if (first < 0) first = k;
         end
      end
      check(bad == 0, req, $sformatf("prefix mismatches code=%0d ratio=%0d wide=%0d inv=%0d first=%0d",
            code, ratio, wide, inv, first), bad, 0);
   endtask

   task automatic density(input int code, input int ratio, input int wide,
                          input logic inv, input string req);
      int   n = len_of(code);
      int   period = (1 << n) - 1;
      int   ones = 0;
      int   exp;
      logic b;
      restart_cfg(code, ratio, wide, inv);
      for (int k = 0; k < period; k++) begin
         next_bit(b);
         if (b === 1'b1) ones++;
      end
      case (ratio)
         0:       exp = 1 << (n - 1);
         1:       exp = 1 << (n - 2);
         2:       exp = 1 << (n - 3);
         default: exp = 0;
      endcase
      if (inv) exp = period - exp;
      check(ones == exp, req, $sformatf("ones per period n=%0d ratio=%0d wide=%0d inv=%0d",
            n, ratio, wide, inv), ones, exp);
   endtask

   function automatic string ratio_req(input int ratio);
      case (ratio)
         0: return "R3";
         1: return "R4";
         2: return "R5";
         default: return "R6";
      endcase
   endfunction

   initial begin
      repeat (WATCHDOG) @(posedge clk);
      if (!finished) begin
         finished = 1;
         checks++;
         failures++;
         $display("FAIL watchdog expired: actual=%0d expected=%0d", WATCHDOG, 0);
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      logic b;
      int   bad;
      rst_n = 1'b0; en = 1'b1; run = 1'b1;
      order_sel = 3'd0; ratio_sel = 2'd0; shift_sel = 1'b0; invert = 1'b1;
      repeat (3) @(negedge clk);
      // R2: output is 0 while reset is held, even with inversion selected.
      check(bit_out === 1'b0, "R2", "output during reset", bit_out, 0);
      rst_n = 1'b1;

      // R1: every order code against the reference recurrence.
      for (int c = 0; c < 8; c++) ref_run(c, 0, 0, 1'b0, "R1");

      // R2: first 31 outputs of order 31 come straight from the all-ones seed.
      restart_cfg(6, 0, 0, 1'b0);
      bad = 0;
      for (int k = 0; k < 31; k++) begin
         next_bit(b);
         if (b !== 1'b1) bad++;
      end
      check(bad == 0, "R2", "seed ones at order 31", bad, 0);

      // R4 R5 R6 R7 R8: order 9, full configuration matrix.
      for (int r = 0; r < 4; r++)
         for (int w = 0; w < 2; w++)
            for (int v = 0; v < 2; v++)
               ref_run(1, r, w, v[0], {ratio_req(r), "/R8/R7"});

      // R3..R8: exact densities over full periods.
      for (int c = 0; c < 3; c++)
         for (int r = 0; r < 4; r++)
            for (int w = 0; w < 2; w++)
               for (int v = 0; v < 2; v++)
                  density(c, r, w, v[0], {ratio_req(r), "/R7/R8"});
      density(3, 0, 0, 1'b0, "R3");

      // R9: enable low freezes the output, then the sequence resumes.
      gen_ref(0);
      restart_cfg(0, 0, 0, 1'b0);
      for (int k = 0; k < 10; k++) next_bit(b);
      en = 1'b0;
      bad = 0;
      for (int k = 0; k < 5; k++) begin
         next_bit(b);
         if (b !== pref[9]) bad++;
      end
      check(bad == 0, "R9", "output held with enable low", bad, 0);
      en = 1'b1;
      bad = 0;
      for (int k = 10; k < 60; k++) begin
         next_bit(b);
         if (b !== pref[k]) bad++;
      end
      check(bad == 0, "R9", "resume after enable pause", bad, 0);

      // R10: configuration changes while running are ignored.
      restart_cfg(0, 0, 0, 1'b0);
      for (int k = 0; k < 5; k++) next_bit(b);
      order_sel = 3'd2; ratio_sel = 2'd3; shift_sel = 1'b1; invert = 1'b1;
      bad = 0;
      for (int k = 5; k < 80; k++) begin
         next_bit(b);
         if (b !== pref[k]) bad++;
      end
      check(bad == 0, "R10", "sequence unchanged by mid-run config", bad, 0);
      @(negedge clk);
      run = 1'b0;
      @(posedge clk);
      @(negedge clk);
      check(bit_out === 1'b0, "R2", "output zero after stop", bit_out, 0);
      run = 1'b1;
      bad = 0;
      for (int k = 0; k < 20; k++) begin
         next_bit(b);
         if (b !== 1'b1) bad++;
      end
      check(bad == 0, "R10", "new config (0/8 inverted) after restart", bad, 0);

      if (!finished) begin
         finished = 1;
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

endmodule